// File: doc/BRIEF.md
# Floating-Point Truncate to Int32-Range Unit

This block takes one IEEE-754 operand, either single or double precision, and rounds it toward zero to an integral value. The result stays in the operand's own floating-point format, but it must also fit the signed 32-bit integer range. The rounding direction is fixed at truncation and does not depend on any dynamic rounding mode.

Any input that cannot be represented in that range is replaced by one fixed saturation pattern, the floating-point encoding of -2^31. This covers NaNs of either kind, infinities and values whose truncation lies outside the range. The unit also reports an invalid-operation flag and an inexact flag.

The result is written into the low element of a 128-bit destination. The bits above that element are either kept from the previous destination value or cleared, under a merge control. A 2-bit precision code selects the format. The two reserved codes give an undefined-encoding indication instead of a result. The datapath has a single register stage: an operand presented with `in_valid` in one cycle shows up at the outputs after the next rising clock edge.

Top module: `fp_trunc_int32`

## Requirements
- R1: A finite operand whose truncation lies in [-2^31, 2^31-1] produces the same-format encoding of that truncated value. Results appear one clock edge after the operand is accepted.
- R2: A zero operand of either sign produces the identical zero, sign kept, with both flags clear.
- R3: `flag_inexact` is set exactly when the result differs numerically from the operand. A nonzero operand with magnitude below 1, subnormals included, yields a zero carrying the operand's sign, with inexact set.
- R4: An infinity, a NaN (quiet or signalling), or an operand whose truncation is at least 2^31 or below -2^31 yields the saturation pattern, with `flag_invalid` set and `flag_inexact` clear. The pattern is 0xCF000000 in single precision and 0xC1E0000000000000 in double precision.
- R5: An operand of exactly -2^31 passes unchanged with no flags. A double-precision operand strictly between -2^31-1 and -2^31 yields the -2^31 pattern with inexact set and invalid clear.
- R6: `prec_sel` = 2'b00 treats `operand[31:0]` as single precision, and 2'b01 treats `operand[63:0]` as double precision.
- R7: `prec_sel[1]` = 1 sets `undef_enc`, clears both flags, and makes `dest_new` equal `dest_old` unchanged.
- R8: For a defined code, the destination bits above the element come from `dest_old` when `merge_en` = 1 and are zero when `merge_en` = 0. The element is 32 bits for single precision and 64 bits for double precision.
- R9: `out_valid` equals `in_valid` delayed by one edge. While `in_valid` is low, `dest_new`, the flags and `undef_enc` hold their values.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| prec_sel | input | 2 | 00 single, 01 double, 1x reserved |
| operand | input | 64 | Source operand, single precision in bits 31:0 |
| dest_old | input | 128 | Previous destination value |
| merge_en | input | 1 | Keep upper destination bits when 1 |
| out_valid | output | 1 | Result registered this cycle |
| dest_new | output | 128 | New destination value |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |
| undef_enc | output | 1 | Reserved precision code seen |

## Verification
The datapath keeps no state beyond one output register. Any wrong decision therefore shows up at the ports on the very edge after the offending operand is accepted. A misclassified exponent would show as a wrong low element: for example, a boundary value near ±2^31 saturating when it should not, or a fraction bit not cleared. It would also show as a flag pair that breaks the invalid-excludes-inexact rule. A wrong merge or hold decision shows in the upper lane bits, or as a register that changes while `in_valid` is low.

// File: rtl/fptr_pkg.sv
package fptr_pkg;

  localparam int INT_W   = 32;
  localparam int LANE_W  = 128;
  localparam int OPND_W  = 64;
  localparam int NUM_FMT = 2;

  typedef enum logic [1:0] {
    PREC_SGL  = 2'b00,
    PREC_DBL  = 2'b01,
    PREC_RSV0 = 2'b10,
    PREC_RSV1 = 2'b11
  } prec_e;

  // exponent / fraction widths per format index (0 = single, 1 = double)
  function automatic int fmt_exp_w(input int idx);
    return (idx == 0) ? 8 : 11;
  endfunction

  function automatic int fmt_frac_w(input int idx);
    return (idx == 0) ? 23 : 52;
  endfunction

endpackage

// File: rtl/fptr_classify.sv
module fptr_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      opnd,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_b,
  output logic [FRAC_W-1:0] frac,
  output logic              exp_zero,
  output logic              exp_max,
  output logic              frac_nz,
  output logic              below_one,
  output logic              above_limit,
  output logic              at_limit,
  output logic [EXP_W-1:0]  e_int
);

  // biased exponent of 1.0 and of 2^(INT_W-1)
  localparam logic [EXP_W-1:0] BIAS    = EXP_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'((1 << (EXP_W - 1)) - 1 + INT_W - 1);

  assign sign  = opnd[W-1];
  assign exp_b = opnd[W-2 -: EXP_W];
  assign frac  = opnd[FRAC_W-1:0];

  assign exp_zero    = (exp_b == '0);
  assign exp_max     = &exp_b;
  assign frac_nz     = |frac;
  assign below_one   = (exp_b < BIAS);
  assign above_limit = (exp_b > EXP_LIM);
  assign at_limit    = (exp_b == EXP_LIM);
  // only meaningful when the exponent is at or above the bias
  assign e_int       = exp_b - BIAS;

endmodule

// File: rtl/fptr_round.sv
module fptr_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         invalid,
  output logic         inexact
);

  localparam logic [EXP_W-1:0]  EXP_LIM   = EXP_W'((1 << (EXP_W - 1)) - 1 + INT_W - 1);
  localparam logic [EXP_W-1:0]  FRAC_E    = EXP_W'(FRAC_W);
  localparam logic [FRAC_W-1:0] FRAC_ONES = {FRAC_W{1'b1}};
  localparam logic [W-1:0]      SAT_PAT   = {1'b1, EXP_LIM, {FRAC_W{1'b0}}};

  logic              sign;
  logic [EXP_W-1:0]  exp_b;
  logic [FRAC_W-1:0] frac;
  logic              exp_zero, exp_max, frac_nz;
  logic              below_one, above_limit, at_limit;
  logic [EXP_W-1:0]  e_int;

  fptr_classify #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .INT_W (INT_W)
  ) u_cls (
    .opnd       (opnd),
    .sign       (sign),
    .exp_b      (exp_b),
    .frac       (frac),
    .exp_zero   (exp_zero),
    .exp_max    (exp_max),
    .frac_nz    (frac_nz),
    .below_one  (below_one),
    .above_limit(above_limit),
    .at_limit   (at_limit),
    .e_int      (e_int)
  );

  // number of fraction bits that sit below the binary point
  logic [EXP_W-1:0]  frac_bits;
  logic [FRAC_W-1:0] keep_mask;
  logic [FRAC_W-1:0] kept;
  logic [FRAC_W-1:0] dropped;

  always_comb begin
    if (e_int >= FRAC_E) frac_bits = '0;
    else                 frac_bits = FRAC_E - e_int;
    keep_mask = FRAC_ONES << frac_bits;
    kept      = frac & keep_mask;
    dropped   = frac & ~keep_mask;
  end

  always_comb begin
    res     = opnd;
    invalid = 1'b0;
    inexact = 1'b0;
    if (exp_max) begin
      res     = SAT_PAT;
      invalid = 1'b1;
    end else if (exp_zero) begin
      res     = {sign, {(W-1){1'b0}}};
      inexact = frac_nz;
    end else if (below_one) begin
      res     = {sign, {(W-1){1'b0}}};
      inexact = 1'b1;
    end else if (above_limit) begin
      res     = SAT_PAT;
      invalid = 1'b1;
    end else if (at_limit && (!sign || (kept != '0))) begin
      res     = SAT_PAT;
      invalid = 1'b1;
    end else begin
      res     = {sign, exp_b, kept};
      inexact = |dropped;
    end
  end

endmodule

// File: rtl/fptr_lane_merge.sv
module fptr_lane_merge #(
  parameter int LANE_W  = 128,
  parameter int OPND_W  = 64,
  parameter int NUM_FMT = 2,
  localparam int IDX_W  = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1
) (
  input  logic [NUM_FMT-1:0][OPND_W-1:0] elem,
  input  logic [IDX_W-1:0]               fmt_idx,
  input  logic [LANE_W-1:0]              old_lane,
  input  logic                           merge_en,
  output logic [LANE_W-1:0]              new_lane
);

  logic [NUM_FMT-1:0][LANE_W-1:0] cand;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int ELEM_W = 32 << g;
    localparam logic [LANE_W-1:0] UPPER =
      {{(LANE_W-ELEM_W){1'b1}}, {ELEM_W{1'b0}}};
    logic [LANE_W-1:0] elem_ext;
    assign elem_ext = {{(LANE_W-OPND_W){1'b0}}, elem[g]};
    assign cand[g]  = (merge_en ? (old_lane & UPPER) : '0) | (elem_ext & ~UPPER);
  end

  assign new_lane = cand[fmt_idx];

endmodule

// File: rtl/fp_trunc_int32.sv
module fp_trunc_int32 (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   prec_sel,
  input  logic [63:0]  operand,
  input  logic [127:0] dest_old,
  input  logic         merge_en,
  output logic         out_valid,
  output logic [127:0] dest_new,
  output logic         flag_invalid,
  output logic         flag_inexact,
  output logic         undef_enc
);
  import fptr_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // per-format datapaths
  logic [NUM_FMT-1:0][OPND_W-1:0] fmt_val;
  logic [NUM_FMT-1:0]             fmt_inv;
  logic [NUM_FMT-1:0]             fmt_inx;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_path
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    localparam int FMT_W = 1 + EW + FW;
    logic [FMT_W-1:0] res_w;
    fptr_round #(
      .EXP_W (EW),
      .FRAC_W(FW),
      .INT_W (INT_W)
    ) u_rnd (
      .opnd   (operand[FMT_W-1:0]),
      .res    (res_w),
      .invalid(fmt_inv[g]),
      .inexact(fmt_inx[g])
    );
    assign fmt_val[g] = OPND_W'(res_w);
  end

  logic [LANE_W-1:0] lane_nx;

  fptr_lane_merge #(
    .LANE_W (LANE_W),
    .OPND_W (OPND_W),
    .NUM_FMT(NUM_FMT)
  ) u_lane (
    .elem    (fmt_val),
    .fmt_idx (prec_sel[0]),
    .old_lane(dest_old),
    .merge_en(merge_en),
    .new_lane(lane_nx)
  );

  // next-state
  logic [LANE_W-1:0] dest_d, dest_q;
  logic              inv_d, inv_q, inx_d, inx_q, und_d, und_q, vld_q;

  always_comb begin
    if (prec_sel[1]) begin
      dest_d = dest_old;
      inv_d  = 1'b0;
      inx_d  = 1'b0;
      und_d  = 1'b1;
    end else begin
      dest_d = lane_nx;
      inv_d  = fmt_inv[prec_sel[0]];
      inx_d  = fmt_inx[prec_sel[0]];
      und_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      dest_q <= '0;
      inv_q  <= 1'b0;
      inx_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        dest_q <= dest_d;
        inv_q  <= inv_d;
        inx_q  <= inx_d;
        und_q  <= und_d;
      end
    end
  end

  assign out_valid    = vld_q;
  assign dest_new     = dest_q;
  assign flag_invalid = inv_q;
  assign flag_inexact = inx_q;
  assign undef_enc    = und_q;

endmodule

// File: rtl/fp_trunc_int32_chk.sv
module fp_trunc_int32_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   prec_sel,
  input logic [127:0] dest_old,
  input logic         merge_en,
  input logic         out_valid,
  input logic [127:0] dest_new,
  input logic         flag_invalid,
  input logic         flag_inexact,
  input logic         undef_enc
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dest_new) && $stable(flag_invalid)
                   && $stable(flag_inexact) && $stable(undef_enc)));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(flag_invalid && flag_inexact));

  // R7
  undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_sel[1]) |=> (undef_enc && !flag_invalid && !flag_inexact
                                   && dest_new == $past(dest_old)));

  // R8
  clear_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prec_sel[1] && !merge_en) |=> (dest_new[127:64] == '0));

  // R4
  sat_sgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec_sel == 2'b00) |=> (!flag_invalid || dest_new[31:0] == 32'hCF00_0000));

endmodule

bind fp_trunc_int32 fp_trunc_int32_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .prec_sel    (prec_sel),
  .dest_old    (dest_old),
  .merge_en    (merge_en),
  .out_valid   (out_valid),
  .dest_new    (dest_new),
  .flag_invalid(flag_invalid),
  .flag_inexact(flag_inexact),
  .undef_enc   (undef_enc)
);

// File: tb/fp_trunc_int32_bench.sv
module fp_trunc_int32_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   prec_sel;
  logic [63:0]  operand;
  logic [127:0] dest_old;
  logic         merge_en;
  logic         out_valid;
  logic [127:0] dest_new;
  logic         flag_invalid, flag_inexact, undef_enc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected registered state
  logic         e_vld;
  logic [127:0] e_dest;
  logic         e_inv, e_inx, e_und;

  always #2 clk = ~clk;

  fp_trunc_int32 u_fp_trunc_int32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prec_sel(prec_sel),
    .operand(operand), .dest_old(dest_old), .merge_en(merge_en),
    .out_valid(out_valid), .dest_new(dest_new), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .undef_enc(undef_enc)
  );

  function automatic real sp_val(input logic [31:0] b);
    int  e = int'(b[30:23]);
    real f = real'(b[22:0]);
    real r;
    if (e == 0) r = f * (2.0 ** (-149));
    else        r = (8388608.0 + f) * (2.0 ** (e - 150));
    return b[31] ? -r : r;
  endfunction

  function automatic logic [31:0] sp_of_int(input logic s, input integer ti);
    longint mag = (ti < 0) ? -longint'(ti) : longint'(ti);
    int     msb = 0;
    longint sh;
    if (mag == 0) return {s, 31'b0};
    for (int i = 0; i < 32; i++) if (mag[i]) msb = i;
    sh = (msb >= 23) ? (mag >> (msb - 23)) : (mag << (23 - msb));
    return {s, 8'(127 + msb), sh[22:0]};
  endfunction

  task automatic model(input logic [1:0] p, input logic [63:0] op,
                       input logic [127:0] old, input logic m,
                       output logic [127:0] d, output logic inv,
                       output logic inx, output logic und);
    logic [63:0] low;
    logic        s, special;
    real         v, tr;
    integer      ti;
    inv = 1'b0; inx = 1'b0; und = 1'b0; low = '0;
    if (p[1]) begin
      d = old; und = 1'b1;
      return;
    end
    if (p == 2'b00) begin
      s = op[31]; special = &op[30:23]; v = sp_val(op[31:0]);
    end else begin
      s = op[63]; special = &op[62:52]; v = $bitstoreal(op);
    end
    if (special || v >= 2147483648.0 || v <= -2147483649.0) begin
      inv = 1'b1;
      low = (p == 2'b00) ? 64'h0000_0000_CF00_0000 : 64'hC1E0_0000_0000_0000;
    end else begin
      ti  = $rtoi(v);
      tr  = real'(ti);
      inx = (tr != v);
      if (p == 2'b00)  low = {32'b0, sp_of_int(s, ti)};
      else if (ti == 0) low = {s, 63'b0};
      else             low = $realtobits(tr);
    end
    d = m ? old : '0;
    if (p == 2'b00) d[31:0] = low[31:0];
    else            d[63:0] = low;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] p, input logic [63:0] op,
                       input logic [127:0] old, input logic m, input string tag);
    string t;
    @(negedge clk);
    in_valid = v; prec_sel = p; operand = op; dest_old = old; merge_en = m;
    if (v) model(p, op, old, m, e_dest, e_inv, e_inx, e_und);
    e_vld = v;
    @(posedge clk);
    #1;
    if (tag != "")   t = tag;
    else if (e_und)  t = "R7";
    else if (e_inv)  t = "R4";
    else if (e_inx)  t = "R3";
    else             t = "R1";
    check("R9", "out_valid", 128'(out_valid), 128'(e_vld));
    check(t, "dest_new", dest_new, e_dest);
    check(t, "flag_invalid", 128'(flag_invalid), 128'(e_inv));
    check(t, "flag_inexact", 128'(flag_inexact), 128'(e_inx));
    check(t, "undef_enc", 128'(undef_enc), 128'(e_und));
    if (v && !p[1]) begin
      if (m) check("R8", "upper kept",
                   dest_new >> (p[0] ? 64 : 32), old >> (p[0] ? 64 : 32));
      else   check("R8", "upper clear",
                   dest_new >> (p[0] ? 64 : 32), 128'd0);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] old_r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; prec_sel = '0; operand = '0;
    dest_old = '0; merge_en = 1'b0;
    e_vld = 1'b0; e_dest = '0; e_inv = 1'b0; e_inx = 1'b0; e_und = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", "out_valid", 128'(out_valid), 128'd0);
    check("R10", "dest_new", dest_new, 128'd0);
    check("R10", "flags", {125'd0, flag_invalid, flag_inexact, undef_enc}, 128'd0);

    old_r = rnd128();
    // single precision corners
    apply(1, 2'b00, 64'h0000_0000, old_r, 0, "R2");
    apply(1, 2'b00, 64'h8000_0000, old_r, 0, "R2");
    apply(1, 2'b00, 64'h3FC0_0000, old_r, 0, "R1");
    apply(1, 2'b00, 64'h4EFF_FFFF, old_r, 0, "R1");
    apply(1, 2'b00, 64'hBF00_0000, old_r, 0, "R3");
    apply(1, 2'b00, 64'h0000_0001, old_r, 0, "R3");
    apply(1, 2'b00, 64'h8040_0000, old_r, 0, "R3");
    apply(1, 2'b00, 64'h7F80_0000, old_r, 0, "R4");
    apply(1, 2'b00, 64'h7FC0_0000, old_r, 0, "R4");
    apply(1, 2'b00, 64'hFF80_0001, old_r, 0, "R4");
    apply(1, 2'b00, 64'h4F00_0000, old_r, 0, "R4");
    apply(1, 2'b00, 64'hCF00_0000, old_r, 0, "R5");
    apply(1, 2'b00, 64'hCF00_0001, old_r, 0, "R4");
    // double precision corners
    apply(1, 2'b01, $realtobits(-2147483648.5), old_r, 0, "R5");
    apply(1, 2'b01, $realtobits(-2147483648.0), old_r, 0, "R5");
    apply(1, 2'b01, $realtobits(-2147483649.0), old_r, 0, "R4");
    apply(1, 2'b01, $realtobits(2147483647.5), old_r, 0, "R1");
    apply(1, 2'b01, $realtobits(2147483648.0), old_r, 0, "R4");
    apply(1, 2'b01, 64'h7FF8_0000_0000_0000, old_r, 0, "R4");
    apply(1, 2'b01, 64'h8000_0000_0000_0001, old_r, 0, "R3");
    apply(1, 2'b01, 64'h8000_0000_0000_0000, old_r, 0, "R2");
    // format select: same operand bits read as single or double
    apply(1, 2'b00, 64'h4009_21FB_5444_2D18, old_r, 0, "R6");
    apply(1, 2'b01, 64'h4009_21FB_5444_2D18, old_r, 0, "R6");
    apply(1, 2'b00, 64'hDEAD_BEEF_4040_0000, old_r, 1, "R6");
    // reserved codes
    apply(1, 2'b10, 64'h7FF8_0000_0000_0000, old_r, 0, "R7");
    apply(1, 2'b11, 64'h3FC0_0000, rnd128(), 1, "R7");
    // merge
    apply(1, 2'b00, 64'hC2F6_E979, rnd128(), 1, "R8");
    apply(1, 2'b01, $realtobits(-12345.75), rnd128(), 1, "R8");
    // hold while idle
    apply(0, 2'b00, 64'h4F80_0000, rnd128(), 1, "R9");
    apply(0, 2'b01, 64'h7FF0_0000_0000_0000, rnd128(), 0, "R9");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [1:0]  p;
      logic [63:0] op;
      logic        s;
      int          sel = int'($urandom % 16);
      p = (sel == 0) ? 2'(2 + ($urandom % 2)) : 2'($urandom % 2);
      s = 1'($urandom);
      if (p == 2'b00) begin
        logic [7:0] e;
        case ($urandom % 8)
          0: e = 8'd0;
          1: e = 8'd255;
          2: e = 8'd157 + 8'($urandom % 3);
          default: e = 8'd110 + 8'($urandom % 50);
        endcase
        op = {$urandom, s, e, 23'($urandom)};
        if ($urandom % 10 == 0) op[22:0] = '0;
      end else begin
        logic [10:0] e;
        case ($urandom % 8)
          0: e = 11'd0;
          1: e = 11'd2047;
          2: e = 11'd1053 + 11'($urandom % 3);
          default: e = 11'd1000 + 11'($urandom % 58);
        endcase
        op = {s, e, 20'($urandom), $urandom};
        if ($urandom % 10 == 0) op[51:0] = '0;
      end
      apply(($urandom % 10) != 0, p, op, rnd128(), 1'($urandom), "");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule